// File: doc/BRIEF.md
# I2C Register-File Target

This block is a bus target for a two-wire serial bus. It answers one fixed 7-bit device address and gives an external bus controller read and write access to a small internal register file. The block runs on a system clock that is much faster than the serial clock. It brings both bus lines in through a two-flop synchronizer and then a three-sample majority filter. It finds START and STOP conditions and bit edges on the filtered levels, and it replies on the data line through an open-drain pull-down.

A write transaction is a control byte followed by a register address and any number of data bytes. The register address is one byte or two bytes long, as set by a static mode input. Each data byte goes to the current pointer, and the pointer then advances. A read transaction first loads the pointer with a write phase, then sends a repeated START and a control byte with the read direction. The target then streams register contents for as long as the controller acknowledges. The register count `REG_DEPTH` must be a power of two no larger than 65536. The pointer wraps from the last entry back to entry 0.

Top module: `i2c_reg_target`

## Requirements
- R1: The first byte after a START is a control byte. Bits 7..1 hold the device address and bit 0 holds the direction (0 = controller writes, 1 = controller reads). When bits 7..1 equal `DEV_ADDR`, the target pulls SDA low during the ninth SCL clock of that byte.
- R2: During a write, the target acknowledges each register-address byte and each data byte by pulling SDA low in the ninth clock.
- R3: When `addrTwoByte` is 1, the register address is two bytes, high byte first. When it is 0, the address is one byte. The pointer is set to the address modulo `REG_DEPTH`.
- R4: Each received data byte is stored at the pointer, and the pointer then advances by one. The pointer wraps from `REG_DEPTH-1` to 0.
- R5: After a control byte with direction 1, the target sends the register at the pointer, MSB first, and advances the pointer. It sends the next register after each controller ACK. After a controller NACK it releases SDA and stays released until the next START.
- R6: After a control byte whose address does not match, the target gives no ACK and drives SDA for none of the following bytes until the next START. The pointer keeps its value.
- R7: Outside START and STOP conditions, the target changes its SDA drive only while SCL is low.
- R8: A falling SDA edge while SCL is high (START) restarts reception at a control byte. A rising SDA edge while SCL is high (STOP) returns the target to idle. A byte cut short by either condition is not stored, and the pointer does not move.
- R9: Both lines pass through a two-flop synchronizer and a 3-sample majority vote. A new sample is taken every `sampleDiv+1` system clocks. A line pulse shorter than one sample period has no effect.
- R10: The only bus output is a pull-down enable for SDA (`sdaPullLow` = 1 pulls the line low). The block never drives a line high, and SDA is released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrTwoByte | input | 1 | Register address length: 1 = two bytes, 0 = one byte (change only while the bus is idle) |
| sampleDiv | input | DIV_W | Filter sample period minus one, in system clocks |
| sclIn | input | 1 | Level of the SCL line |
| sdaIn | input | 1 | Level of the SDA line |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the target with `REG_DEPTH = 512`, `DEV_ADDR = 7'h3A` and `sampleDiv = 1`. With a 9-bit pointer, bit 0 of the high address byte selects a different register. A missing, ignored or swapped high byte therefore changes which entry a later one-byte-mode read returns. The top entry sits at 0x1FF, so a burst can cross the wrap point. A sample period of two clocks lets a one-clock SCL pulse test the majority filter, while a 64-clock serial bit keeps a full random transaction mix within the run length.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_OUT,
    PH_TX,
    PH_ACK_IN
  } phase_e;

  typedef enum logic [1:0] {
    K_CTRL,
    K_ADDR_HI,
    K_ADDR_LO,
    K_DATA
  } kind_e;

  // strobes from control to datapath, at most one shift source per cycle
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic writeReg;
    logic loadHi;
    logic loadPtr;
    logic bumpPtr;
  } dpCmd_t;

endpackage

// File: rtl/i2c_tgt_front.sv
module i2c_tgt_front #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] sampleDiv,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclLvl,
  output logic             sdaLvl,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startSeen,
  output logic             stopSeen
);

  logic [1:0]       sclSync, sdaSync;
  logic [DIV_W-1:0] tickCnt;
  logic             tick;
  logic [2:0]       sclWin, sdaWin;
  logic             sclF, sdaF, sclD, sdaD;

  function automatic logic vote3(input logic [2:0] w);
    return (w[0] & w[1]) | (w[1] & w[2]) | (w[0] & w[2]);
  endfunction

  assign tick = (tickCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      tickCnt <= '0;
      sclWin  <= 3'b111;
      sdaWin  <= 3'b111;
      sclF    <= 1'b1;
      sdaF    <= 1'b1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      tickCnt <= tick ? sampleDiv : tickCnt - DIV_W'(1);
      if (tick) begin
        sclWin <= {sclWin[1:0], sclSync[1]};
        sdaWin <= {sdaWin[1:0], sdaSync[1]};
      end
      sclF <= vote3(sclWin);
      sdaF <= vote3(sdaWin);
      sclD <= sclF;
      sdaD <= sdaF;
    end
  end

  assign sclLvl    = sclF;
  assign sdaLvl    = sdaF;
  assign sclRise   = sclF & ~sclD;
  assign sclFall   = ~sclF & sclD;
  assign startSeen = sclF & sclD & sdaD & ~sdaF;
  assign stopSeen  = sclF & sclD & ~sdaD & sdaF;

  // R9: a filtered level only moves two cycles after a sample tick
  p_filter_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sclF) || !$stable(sdaF)) |-> $past(tick, 2));

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int REG_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrTwoByte,
  input  logic       sdaLvl,
  input  dpCmd_t     cmd,
  output logic [7:0] rxByte,
  output logic       txMsb
);

  localparam int PTR_W = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;

  logic [7:0]       regFile [REG_DEPTH];
  logic [7:0]       shReg;
  logic [7:0]       hiByte;
  logic [PTR_W-1:0] ptr;
  logic [15:0]      fullAddr;

  assign fullAddr = addrTwoByte ? {hiByte, shReg} : {8'h00, shReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      hiByte <= '0;
      ptr    <= '0;
      for (int i = 0; i < REG_DEPTH; i++) regFile[i] <= '0;
    end else begin
      if (cmd.shiftIn)      shReg <= {shReg[6:0], sdaLvl};
      else if (cmd.loadTx)  shReg <= regFile[ptr];
      else if (cmd.shiftTx) shReg <= {shReg[6:0], 1'b0};

      if (cmd.writeReg) regFile[ptr] <= shReg;
      if (cmd.loadHi)   hiByte <= shReg;

      if (cmd.loadPtr)      ptr <= PTR_W'(fullAddr);
      else if (cmd.bumpPtr) ptr <= ptr + PTR_W'(1);
    end
  end

  assign rxByte = shReg;
  assign txMsb  = shReg[7];

  // R8: the control never asks for two shift-register sources at once
  p_one_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.shiftIn, cmd.loadTx, cmd.shiftTx}));

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrTwoByte,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCmd_t     cmd,
  output logic       sdaPullLow
);

  phase_e     phase;
  kind_e      kind;
  logic [3:0] bitCnt;
  logic       ackDrive;
  logic       readDir;
  logic       ackSeen;
  logic       busEvent;

  assign busEvent = startSeen | stopSeen;

  function automatic kind_e nextKind(input kind_e k, input logic twoB);
    case (k)
      K_CTRL:    return twoB ? K_ADDR_HI : K_ADDR_LO;
      K_ADDR_HI: return K_ADDR_LO;
      default:   return K_DATA;
    endcase
  endfunction

  always_comb begin
    cmd = '0;
    if (!busEvent) begin
      case (phase)
        PH_RX: begin
          if (sclRise && bitCnt != 4'd8) cmd.shiftIn = 1'b1;
          else if (sclFall && bitCnt == 4'd8) begin
            case (kind)
              K_ADDR_HI: cmd.loadHi = 1'b1;
              K_ADDR_LO: cmd.loadPtr = 1'b1;
              K_DATA: begin
                cmd.writeReg = 1'b1;
                cmd.bumpPtr  = 1'b1;
              end
              default: ;
            endcase
          end
        end
        PH_ACK_OUT: if (sclFall && kind == K_CTRL && readDir) begin
          cmd.loadTx  = 1'b1;
          cmd.bumpPtr = 1'b1;
        end
        PH_TX: if (sclFall && bitCnt != 4'd7) cmd.shiftTx = 1'b1;
        PH_ACK_IN: if (sclFall && ackSeen) begin
          cmd.loadTx  = 1'b1;
          cmd.bumpPtr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      kind     <= K_CTRL;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      readDir  <= 1'b0;
      ackSeen  <= 1'b0;
    end else if (startSeen) begin
      phase    <= PH_RX;
      kind     <= K_CTRL;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopSeen) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
          else if (sclFall && bitCnt == 4'd8) begin
            if (kind != K_CTRL) begin
              ackDrive <= 1'b1;
              phase    <= PH_ACK_OUT;
            end else if (rxByte[7:1] == DEV_ADDR) begin
              ackDrive <= 1'b1;
              readDir  <= rxByte[0];
              phase    <= PH_ACK_OUT;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_ACK_OUT: if (sclFall) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          phase    <= (kind == K_CTRL && readDir) ? PH_TX : PH_RX;
          kind     <= nextKind(kind, addrTwoByte);
        end
        PH_TX: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            phase  <= PH_ACK_IN;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end
        PH_ACK_IN: begin
          if (sclRise) ackSeen <= ~sdaLvl;
          if (sclFall) begin
            bitCnt <= '0;
            phase  <= ackSeen ? PH_TX : PH_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaPullLow = (phase == PH_TX) ? ~txMsb : ackDrive;

  // R8: a START always leaves the target waiting for a fresh control byte
  p_start_resync_r8: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (phase == PH_RX && kind == K_CTRL && bitCnt == 4'd0));

  // R6: while idle (unmatched address, after NACK or STOP) SDA is released
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !sdaPullLow);

  // R2: an acknowledge is only started right after an SCL falling edge
  p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(sclFall));

  // R5: a controller NACK ends transmission and releases the line
  p_nack_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACK_IN && sclFall && !ackSeen && !busEvent)
      |=> (phase == PH_IDLE && !sdaPullLow));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         REG_DEPTH = 16,
  parameter int         DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrTwoByte,
  input  logic [DIV_W-1:0] sampleDiv,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow
);

  logic       sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic [7:0] rxByte;
  logic       txMsb;
  dpCmd_t     cmd;

  i2c_tgt_front #(.DIV_W(DIV_W)) front_i (
    .clk       (clk),
    .rstN      (rstN),
    .sampleDiv (sampleDiv),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclLvl    (sclLvl),
    .sdaLvl    (sdaLvl),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .addrTwoByte (addrTwoByte),
    .sclRise     (sclRise),
    .sclFall     (sclFall),
    .startSeen   (startSeen),
    .stopSeen    (stopSeen),
    .sdaLvl      (sdaLvl),
    .rxByte      (rxByte),
    .txMsb       (txMsb),
    .cmd         (cmd),
    .sdaPullLow  (sdaPullLow)
  );

  i2c_tgt_dp #(.REG_DEPTH(REG_DEPTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .addrTwoByte (addrTwoByte),
    .sdaLvl      (sdaLvl),
    .cmd         (cmd),
    .rxByte      (rxByte),
    .txMsb       (txMsb)
  );

  // R7: apart from bus conditions, SDA drive moves only while filtered SCL is low
  p_sda_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !$past(startSeen || stopSeen)) |-> !$past(sclLvl));

endmodule

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

  localparam logic [6:0] DEV   = 7'h3A;
  localparam int         DEPTH = 512;
  localparam int         Q     = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrTwoByte = 1'b0;
  logic [7:0] sampleDiv = 8'd1;
  logic       sclCtl = 1'b1;
  logic       sdaCtl = 1'b1;
  logic       sdaPullLow;
  logic       sdaBus;

  assign sdaBus = sdaCtl & ~sdaPullLow;

  always #5 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .REG_DEPTH(DEPTH), .DIV_W(8)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .addrTwoByte (addrTwoByte),
    .sampleDiv   (sampleDiv),
    .sclIn       (sclCtl),
    .sdaIn       (sdaBus),
    .sdaPullLow  (sdaPullLow)
  );

  int         nChecks = 0;
  int         nFail = 0;
  int         sclHighMoves = 0;
  int         ptrModel = 0;
  bit         done = 0;
  logic       prevPull = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] wrBuf [8];

  // R7 monitor: target drive must not move while the controller holds SCL high
  always @(negedge clk) begin
    if (rstN && (sdaPullLow !== prevPull) && sclCtl) sclHighMoves++;
    prevPull = sdaPullLow;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  function automatic logic [7:0] expReg(input int a);
    return model[a % DEPTH];
  endfunction

  task automatic tq(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic startC();
    sdaCtl = 1'b1; tq();
    sclCtl = 1'b1; tq();
    sdaCtl = 1'b0; tq();
    sclCtl = 1'b0; tq();
  endtask

  task automatic stopC();
    sdaCtl = 1'b0; tq();
    sclCtl = 1'b1; tq();
    sdaCtl = 1'b1; tq(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb, input int glitchBit);
    for (int i = 7; i >= 8 - nb; i--) begin
      sdaCtl = b[i]; tq();
      sclCtl = 1'b1;
      if (i == glitchBit) begin
        tq();
        sclCtl = 1'b0;
        @(posedge clk); #1;
        sclCtl = 1'b1;
        tq();
      end else begin
        tq(2);
      end
      sclCtl = 1'b0; tq();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input int glitchBit, output bit acked);
    sendBits(b, 8, glitchBit);
    sdaCtl = 1'b1; tq();
    sclCtl = 1'b1; tq();
    acked = !sdaBus;
    tq();
    sclCtl = 1'b0; tq();
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sdaCtl = 1'b1; tq();
      sclCtl = 1'b1; tq();
      b = {b[6:0], sdaBus};
      tq();
      sclCtl = 1'b0; tq();
    end
    sdaCtl = !ackIt; tq();
    sclCtl = 1'b1; tq(2);
    sclCtl = 1'b0; tq();
    sdaCtl = 1'b1;
  endtask

  task automatic sendAddr(input bit two, input int addr);
    bit a;
    if (two) begin
      sendByte(8'(addr >> 8), -1, a);
      chk(a, "R3 ack on high address byte", int'(a), 1);
    end
    sendByte(8'(addr), -1, a);
    chk(a, "R2 ack on address byte", int'(a), 1);
  endtask

  task automatic doWrite(input bit two, input int addr, input int n, input int glitchAt);
    bit a;
    addrTwoByte = two;
    startC();
    sendByte({DEV, 1'b0}, -1, a);
    chk(a, "R1 ack on matching write control byte", int'(a), 1);
    sendAddr(two, addr);
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], (i == 0) ? glitchAt : -1, a);
      chk(a, "R2 ack on data byte", int'(a), 1);
      model[(addr + i) % DEPTH] = wrBuf[i];
    end
    stopC();
    ptrModel = (addr + n) % DEPTH;
  endtask

  task automatic readTail(input int n, input string tag);
    bit a;
    logic [7:0] b;
    sendByte({DEV, 1'b1}, -1, a);
    chk(a, "R1 ack on matching read control byte", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      chk(b == expReg(ptrModel + i), tag, int'(b), int'(expReg(ptrModel + i)));
    end
    chk(!sdaPullLow, "R5 SDA released after NACK", int'(sdaPullLow), 0);
    stopC();
    ptrModel = (ptrModel + n) % DEPTH;
  endtask

  task automatic doRead(input bit two, input int addr, input int n, input string tag);
    bit a;
    addrTwoByte = two;
    startC();
    sendByte({DEV, 1'b0}, -1, a);
    chk(a, "R1 ack on write control byte before read", int'(a), 1);
    sendAddr(two, addr);
    ptrModel = addr % DEPTH;
    startC();
    readTail(n, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      report();
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    tq();

    chk(sdaPullLow == 1'b0, "R10 SDA released after reset", int'(sdaPullLow), 0);

    // one-byte address, single write and read back
    wrBuf[0] = 8'hA5;
    doWrite(0, 'h12, 1, -1);
    doRead(0, 'h12, 1, "R1 one-byte mode read back");

    // two-byte address, burst with high byte selecting the upper half
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33; wrBuf[3] = 8'h44;
    doWrite(1, 'h1F0, 4, -1);
    doRead(1, 'h1F0, 4, "R3 two-byte burst read back");
    doRead(0, 'hF0, 1, "R3 high byte must place data above 0xFF");

    // burst across the wrap point
    wrBuf[0] = 8'h9C; wrBuf[1] = 8'h9D; wrBuf[2] = 8'h9E; wrBuf[3] = 8'h9F;
    doWrite(1, 'h1FE, 4, -1);
    doRead(1, 'h1FE, 4, "R4 burst read across wrap");
    doRead(0, 'h00, 2, "R4 entries 0 and 1 filled by wrap");

    // byte cut short by STOP
    wrBuf[0] = 8'h5A; wrBuf[1] = 8'h6B;
    doWrite(0, 'h40, 2, -1);
    addrTwoByte = 1'b0;
    startC();
    sendByte({DEV, 1'b0}, -1, a);
    sendAddr(0, 'h40);
    sendBits(8'hFF, 4, -1);
    stopC();
    doRead(0, 'h40, 1, "R8 STOP mid-byte stores nothing");

    // byte cut short by repeated START, then read from the unmoved pointer
    startC();
    sendByte({DEV, 1'b0}, -1, a);
    sendAddr(0, 'h41);
    sendBits(8'h00, 5, -1);
    startC();
    ptrModel = 'h41;
    readTail(1, "R8 repeated START mid-byte stores nothing");

    // one-clock SCL glitch while SCL is high
    wrBuf[0] = 8'hC3;
    doWrite(0, 'h80, 1, 4);
    doRead(0, 'h80, 1, "R9 short SCL pulse rejected");

    // random mix of modes, addresses and burst lengths
    for (int t = 0; t < 8; t++) begin
      bit two;
      int addr, n;
      two  = 1'($urandom % 2);
      addr = two ? int'($urandom % DEPTH) : int'($urandom % 256);
      n    = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wrBuf[i] = 8'($urandom);
      doWrite(two, addr, n, -1);
      doRead(two, addr, n, "R4 random burst read back");
    end

    // address mismatch on write and on read, then current-address read
    addrTwoByte = 1'b0;
    startC();
    sendByte({DEV ^ 7'h01, 1'b0}, -1, a);
    chk(!a, "R6 no ack for other address", int'(a), 0);
    sendByte(8'h07, -1, a);
    chk(!a, "R6 no ack after mismatch", int'(a), 0);
    stopC();
    startC();
    sendByte({DEV ^ 7'h40, 1'b1}, -1, a);
    chk(!a, "R6 no ack for other address read", int'(a), 0);
    recvByte(1'b0, b);
    chk(b == 8'hFF, "R6 line left released", int'(b), 'hFF);
    stopC();
    startC();
    readTail(2, "R6 pointer kept across mismatch");

    chk(sclHighMoves == 0, "R7 SDA drive moved while SCL high", sclHighMoves, 0);

    done = 1;
    report();
  end

endmodule